// File: doc/BRIEF.md
# Power-Up Sequencing Controller

This block is the digital sequencer of a portable-device power manager. It sits in standby until a wake source (push button, charger detect or USB power detect) has been held steadily for a debounce window measured in 1 ms ticks. It then raises a status flag to the host and turns on the low-dropout rails and the first buck rail together. The second and third buck rails follow at fixed offsets, and the system reset is released once the last rail is up.

After reset release the host must confirm power-on within a deadline, through a register bit or a dedicated acknowledge pin. If it does not, the block drops back to standby. Once active, a further debounced button press only raises the status flag. Power stays on until the host clears both acknowledge sources, and even then only if no external supply is present. A battery-low alarm forces standby from any powered state. Entering standby turns every rail off in the same cycle and clears reset, status and the acknowledge register bit. It also rearms the debouncer.

Host register writes use a 4-bit word: bit 0 is the acknowledge bit, bit 1 enables the second LDO, bit 2 enables the second buck rail and bit 3 enables the third buck rail. The first buck rail has no register control.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset all rail enables, statusOut and rstOutN are 0.
- R2: A wake source (btnIn, chgDetIn or usbDetIn, any one high) is accepted only after it has been high through DEB_TICKS consecutive ticks (default 32). Any low cycle restarts the count, so shorter pulses never power the block up.
- R3: On acceptance, one clock after the accepting tick, ldo1En, buck1En and statusOut go high together. An event that matures while battLow is high is dropped.
- R4: ldo2En comes on with ldo1En if ldo2Strap is high at any time while rstOutN is low. Otherwise it is on only while the device is powered and either register bit 1 or ldo2PinEn is high.
- R5: buck2En rises BUCK2_TICKS ticks (default 15) after acceptance, and buck3En rises BUCK3_TICKS ticks (default 20) after buck2En.
- R6: rstOutN rises RST_TICKS ticks (default 60) after buck3En.
- R7: If neither register bit 0 nor ackPin is high within ACK_TICKS ticks (default 128) of reset release, every output returns to 0. If either is high first, the block goes active and statusOut clears.
- R8: While active, a debounced btnIn press sets statusOut and leaves every rail and rstOutN unchanged.
- R9: While active, power-down happens only when register bit 0 and ackPin are both low. Either one high keeps everything on.
- R10: While active, usbDetIn or chgDetIn high blocks the acknowledge-clear power-down.
- R11: battLow high in any powered state returns every output to 0 on the next clock.
- R12: Register bits 2 and 3 gate buck2En and buck3En. No write can turn buck1En off. Writes are ignored while rstOutN is low.
- R13: Standby entry clears all rails, statusOut, rstOutN and register bit 0, so a later wake needs a fresh acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick1ms | input | 1 | One-clock pulse every millisecond |
| btnIn | input | 1 | Push button, high when pressed |
| chgDetIn | input | 1 | Charger input present |
| usbDetIn | input | 1 | USB power present |
| battLow | input | 1 | Battery-low alarm |
| ldo2Strap | input | 1 | Auto-enable strap for the second LDO |
| ldo2PinEn | input | 1 | Pin enable for the second LDO |
| ackPin | input | 1 | Host power acknowledge pin |
| regWrEn | input | 1 | Host register write strobe |
| regWrData | input | 4 | Write data: bit0 ack, bit1 LDO2, bit2 buck2, bit3 buck3 |
| ldo1En | output | 1 | First LDO enable |
| ldo2En | output | 1 | Second LDO enable |
| buck1En | output | 1 | First buck enable |
| buck2En | output | 1 | Second buck enable |
| buck3En | output | 1 | Third buck enable |
| statusOut | output | 1 | Event flag to the host |
| rstOutN | output | 1 | System reset, active low |

## Verification
The bench fires random sub-threshold pulses on randomly chosen wake sources, plus a directed case of two 20-tick pulses split by a two-cycle gap. A debouncer that kept its count across a dropout would wake on these. Each staged turn-on is sampled one tick before and just after its edge, so an off-by-one timer shows up at one of the two samples. The deadline is probed at its last tick and just past it on a wake that follows an earlier register acknowledge; if standby failed to clear the bit, power would stay on there. Random mixes of the two acknowledge sources, both supply detects and battery-low are compared against a bench model of the shutdown rule, which catches a controller that drops power on one cleared source or ignores a present supply.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int REG_W     = 4;
  localparam int ACK_BIT   = 0;
  localparam int LDO2_BIT  = 1;
  localparam int BUCK2_BIT = 2;
  localparam int BUCK3_BIT = 3;

  typedef enum logic [2:0] {
    ST_STANDBY,
    ST_RAMP_B2,
    ST_RAMP_B3,
    ST_RST_WAIT,
    ST_ACK_WAIT,
    ST_ACTIVE
  } seqState_t;

  typedef struct packed {
    logic powerUp;
    logic powerDown;
    logic clrTmr;
    logic onBuck2;
    logic onBuck3;
    logic relRst;
    logic setStatus;
    logic clrStatus;
    logic btnOnly;
  } seqStrobe_t;

endpackage

// File: rtl/pwr_seq_debounce.sv
module pwr_seq_debounce #(
  parameter int DEB_TICKS = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic rearm,
  input  logic evtIn,
  output logic accept
);

  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(DEB_TICKS);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= '0;
    else if (rearm || !evtIn)      cnt <= '0;
    else if (tick && cnt != FULL)  cnt <= cnt + 1'b1;
  end

  assign accept = evtIn && tick && !rearm && (cnt == LAST);

  // R2: a running count means the source was high on the previous cycle
  assert_count_needs_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> $past(evtIn))
    else $error("debounce count advanced without a held event");

endmodule

// File: rtl/pwr_seq_datapath.sv
module pwr_seq_datapath
  import pwr_seq_pkg::*;
#(
  parameter int DEB_TICKS = 32,
  parameter int TMR_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  seqStrobe_t       strb,
  input  logic             btnIn,
  input  logic             chgDetIn,
  input  logic             usbDetIn,
  input  logic             ldo2Strap,
  input  logic             ldo2PinEn,
  input  logic             ackPin,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic             wakeAccept,
  output logic [TMR_W-1:0] tmrCount,
  output logic             ackAny,
  output logic             ldo1En,
  output logic             ldo2En,
  output logic             buck1En,
  output logic             buck2En,
  output logic             buck3En,
  output logic             statusOut,
  output logic             rstOutN
);

  logic ldo1R, buck1R, buck2Seq, buck3Seq;
  logic cfgLdo2, cfgBuck2, cfgBuck3, ackReg;
  logic ldo2Auto, statusR, rstR;
  logic debEvt;

  assign debEvt = strb.btnOnly ? btnIn : (btnIn | chgDetIn | usbDetIn);

  pwr_seq_debounce #(.DEB_TICKS(DEB_TICKS)) uDeb (
    .clk   (clk),
    .rstN  (rstN),
    .tick  (tick),
    .rearm (strb.powerDown),
    .evtIn (debEvt),
    .accept(wakeAccept)
  );

  // interval timer shared by every sequencing stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   tmrCount <= '0;
    else if (strb.clrTmr)        tmrCount <= '0;
    else if (tick && tmrCount != '1) tmrCount <= tmrCount + 1'b1;
  end

  // rail and handshake state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldo1R    <= 1'b0;
      buck1R   <= 1'b0;
      buck2Seq <= 1'b0;
      buck3Seq <= 1'b0;
      ldo2Auto <= 1'b0;
      statusR  <= 1'b0;
      rstR     <= 1'b0;
    end else if (strb.powerDown) begin
      ldo1R    <= 1'b0;
      buck1R   <= 1'b0;
      buck2Seq <= 1'b0;
      buck3Seq <= 1'b0;
      ldo2Auto <= 1'b0;
      statusR  <= 1'b0;
      rstR     <= 1'b0;
    end else begin
      if (strb.powerUp) begin
        ldo1R    <= 1'b1;
        buck1R   <= 1'b1;
        ldo2Auto <= ldo2Strap;
      end else if (ldo1R && !rstR) begin
        ldo2Auto <= ldo2Auto | ldo2Strap;
      end
      if (strb.onBuck2) buck2Seq <= 1'b1;
      if (strb.onBuck3) buck3Seq <= 1'b1;
      if (strb.relRst)  rstR     <= 1'b1;
      if (strb.powerUp || strb.setStatus) statusR <= 1'b1;
      else if (strb.clrStatus)            statusR <= 1'b0;
    end
  end

  // host register, writable only once the host is out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackReg   <= 1'b0;
      cfgLdo2  <= 1'b0;
      cfgBuck2 <= 1'b1;
      cfgBuck3 <= 1'b1;
    end else if (strb.powerDown) begin
      ackReg   <= 1'b0;
      cfgLdo2  <= 1'b0;
      cfgBuck2 <= 1'b1;
      cfgBuck3 <= 1'b1;
    end else if (regWrEn && rstR) begin
      ackReg   <= regWrData[ACK_BIT];
      cfgLdo2  <= regWrData[LDO2_BIT];
      cfgBuck2 <= regWrData[BUCK2_BIT];
      cfgBuck3 <= regWrData[BUCK3_BIT];
    end
  end

  assign ackAny    = ackReg | ackPin;
  assign ldo1En    = ldo1R;
  assign ldo2En    = ldo1R & (ldo2Auto | cfgLdo2 | ldo2PinEn);
  assign buck1En   = buck1R;
  assign buck2En   = buck2Seq & cfgBuck2;
  assign buck3En   = buck3Seq & cfgBuck3;
  assign statusOut = statusR;
  assign rstOutN   = rstR;

  // R12: the first buck rail stays on for as long as the device is powered
  assert_buck1_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ldo1R && $past(ldo1R)) |-> buck1R)
    else $error("buck1 dropped while powered");

  // R6: reset is released only after both staged buck rails were sequenced
  assert_rst_after_rails_R6: assert property (@(posedge clk) disable iff (!rstN)
    rstR |-> (buck2Seq && buck3Seq && ldo1R))
    else $error("reset released before the rail sequence finished");

  // R8: a status rise never comes with power removal
  assert_status_keeps_power_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusR) |-> ldo1R)
    else $error("status raised without power");

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int BUCK2_TICKS = 15,
  parameter int BUCK3_TICKS = 20,
  parameter int RST_TICKS   = 60,
  parameter int ACK_TICKS   = 128,
  parameter int TMR_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wakeAccept,
  input  logic [TMR_W-1:0] tmrCount,
  input  logic             ackAny,
  input  logic             supplyAny,
  input  logic             battLow,
  output seqStrobe_t       strb
);

  seqState_t state, stateNxt;

  function automatic logic tmrHit(input int lim);
    return tick && (tmrCount == TMR_W'(lim - 1));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_STANDBY;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt     = state;
    strb         = '0;
    strb.btnOnly = (state != ST_STANDBY);
    if (state != ST_STANDBY && battLow) begin
      strb.powerDown = 1'b1;
      strb.clrTmr    = 1'b1;
      stateNxt       = ST_STANDBY;
    end else begin
      unique case (state)
        ST_STANDBY: if (wakeAccept && !battLow) begin
          strb.powerUp = 1'b1;
          strb.clrTmr  = 1'b1;
          stateNxt     = ST_RAMP_B2;
        end
        ST_RAMP_B2: if (tmrHit(BUCK2_TICKS)) begin
          strb.onBuck2 = 1'b1;
          strb.clrTmr  = 1'b1;
          stateNxt     = ST_RAMP_B3;
        end
        ST_RAMP_B3: if (tmrHit(BUCK3_TICKS)) begin
          strb.onBuck3 = 1'b1;
          strb.clrTmr  = 1'b1;
          stateNxt     = ST_RST_WAIT;
        end
        ST_RST_WAIT: if (tmrHit(RST_TICKS)) begin
          strb.relRst = 1'b1;
          strb.clrTmr = 1'b1;
          stateNxt    = ST_ACK_WAIT;
        end
        ST_ACK_WAIT: begin
          if (ackAny) begin
            strb.clrStatus = 1'b1;
            stateNxt       = ST_ACTIVE;
          end else if (tmrHit(ACK_TICKS)) begin
            strb.powerDown = 1'b1;
            strb.clrTmr    = 1'b1;
            stateNxt       = ST_STANDBY;
          end
        end
        ST_ACTIVE: begin
          if (!ackAny && !supplyAny) begin
            strb.powerDown = 1'b1;
            strb.clrTmr    = 1'b1;
            stateNxt       = ST_STANDBY;
          end else if (wakeAccept) begin
            strb.setStatus = 1'b1;
          end
        end
        default: stateNxt = ST_STANDBY;
      endcase
    end
  end

  // R11: battery low always lands in standby
  assert_batt_low_standby_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_STANDBY && battLow) |=> (state == ST_STANDBY))
    else $error("battery low did not force standby");

  // R10: an external supply keeps the active state
  assert_supply_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && supplyAny && !battLow) |=> (state == ST_ACTIVE))
    else $error("shutdown while an external supply was present");

  // R9: one acknowledge source still high keeps the active state
  assert_ack_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && ackAny && !battLow) |=> (state == ST_ACTIVE))
    else $error("shutdown while an acknowledge source was high");

  // R3: leaving standby only happens on an accepted event
  assert_wake_on_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STANDBY && !wakeAccept) |=> (state == ST_STANDBY))
    else $error("left standby without an accepted event");

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int DEB_TICKS   = 32,
  parameter int BUCK2_TICKS = 15,
  parameter int BUCK3_TICKS = 20,
  parameter int RST_TICKS   = 60,
  parameter int ACK_TICKS   = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick1ms,
  input  logic             btnIn,
  input  logic             chgDetIn,
  input  logic             usbDetIn,
  input  logic             battLow,
  input  logic             ldo2Strap,
  input  logic             ldo2PinEn,
  input  logic             ackPin,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic             ldo1En,
  output logic             ldo2En,
  output logic             buck1En,
  output logic             buck2En,
  output logic             buck3En,
  output logic             statusOut,
  output logic             rstOutN
);

  localparam int MAX_A  = (BUCK2_TICKS > BUCK3_TICKS) ? BUCK2_TICKS : BUCK3_TICKS;
  localparam int MAX_B  = (RST_TICKS > ACK_TICKS) ? RST_TICKS : ACK_TICKS;
  localparam int MAX_IV = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W  = $clog2(MAX_IV + 1);

  seqStrobe_t       strb;
  logic             wakeAccept;
  logic             ackAny;
  logic [TMR_W-1:0] tmrCount;

  pwr_seq_fsm #(
    .BUCK2_TICKS(BUCK2_TICKS),
    .BUCK3_TICKS(BUCK3_TICKS),
    .RST_TICKS  (RST_TICKS),
    .ACK_TICKS  (ACK_TICKS),
    .TMR_W      (TMR_W)
  ) uFsm (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick1ms),
    .wakeAccept(wakeAccept),
    .tmrCount  (tmrCount),
    .ackAny    (ackAny),
    .supplyAny (usbDetIn | chgDetIn),
    .battLow   (battLow),
    .strb      (strb)
  );

  pwr_seq_datapath #(
    .DEB_TICKS(DEB_TICKS),
    .TMR_W    (TMR_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick1ms),
    .strb      (strb),
    .btnIn     (btnIn),
    .chgDetIn  (chgDetIn),
    .usbDetIn  (usbDetIn),
    .ldo2Strap (ldo2Strap),
    .ldo2PinEn (ldo2PinEn),
    .ackPin    (ackPin),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .wakeAccept(wakeAccept),
    .tmrCount  (tmrCount),
    .ackAny    (ackAny),
    .ldo1En    (ldo1En),
    .ldo2En    (ldo2En),
    .buck1En   (buck1En),
    .buck2En   (buck2En),
    .buck3En   (buck3En),
    .statusOut (statusOut),
    .rstOutN   (rstOutN)
  );

endmodule

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;

  localparam int DEB = 32;
  localparam int B2  = 15;
  localparam int B3  = 20;
  localparam int RST = 60;
  localparam int ACK = 128;
  localparam int T1  = DEB + B2;
  localparam int T2  = T1 + B3;
  localparam int T3  = T2 + RST;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick1ms = 1'b0;
  logic btnIn = 0, chgDetIn = 0, usbDetIn = 0, battLow = 0;
  logic ldo2Strap = 0, ldo2PinEn = 0, ackPin = 0, regWrEn = 0;
  logic [3:0] regWrData = '0;
  logic ldo1En, ldo2En, buck1En, buck2En, buck3En, statusOut, rstOutN;

  int cyc = 0;
  int tdiv = 0;
  int nTests = 0;
  int nFail = 0;
  bit curStrap = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick1ms = (tdiv == 0);
  end

  pwr_seq_ctrl #(.DEB_TICKS(DEB), .BUCK2_TICKS(B2), .BUCK3_TICKS(B3),
                 .RST_TICKS(RST), .ACK_TICKS(ACK)) u0 (
    .clk(clk), .rstN(rstN), .tick1ms(tick1ms), .btnIn(btnIn), .chgDetIn(chgDetIn),
    .usbDetIn(usbDetIn), .battLow(battLow), .ldo2Strap(ldo2Strap), .ldo2PinEn(ldo2PinEn),
    .ackPin(ackPin), .regWrEn(regWrEn), .regWrData(regWrData), .ldo1En(ldo1En),
    .ldo2En(ldo2En), .buck1En(buck1En), .buck2En(buck2En), .buck3En(buck3En),
    .statusOut(statusOut), .rstOutN(rstOutN));

  wire [6:0] vec = {rstOutN, statusOut, buck3En, buck2En, buck1En, ldo2En, ldo1En};

  // reference: outputs t ticks after a wake source was raised, before any acknowledge
  function automatic logic [6:0] expRamp(input int t, input bit s);
    bit on = (t >= DEB);
    return {t >= T3, on, t >= T2, t >= T1, on, on & s, on};
  endfunction

  function automatic logic [6:0] expActive(input bit st);
    return {1'b1, st, 1'b1, 1'b1, 1'b1, curStrap, 1'b1};
  endfunction

  function automatic bit expDown(input bit ar, input bit ap, input bit u, input bit c, input bit bl);
    return bl | (!ar & !ap & !u & !c);
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic gotoCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setSrc(input int src, input logic v);
    case (src)
      0: btnIn = v;
      1: chgDetIn = v;
      default: usbDetIn = v;
    endcase
  endtask

  task automatic writeReg(input logic [3:0] d);
    regWrData = d;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
  endtask

  // wake, check every staged edge one tick early and just after, stop at reset release
  task automatic powerOn(input int src, input bit strap, output int start);
    int ms[4];
    string tg[4];
    ms = '{DEB, T1, T2, T3};
    tg = '{"R3 wake", "R5 buck2", "R5 buck3", "R6 reset"};
    ldo2Strap = strap;
    curStrap = strap;
    setSrc(src, 1'b1);
    start = cyc;
    for (int i = 0; i < 4; i++) begin
      gotoCyc(start + 4 * (ms[i] - 1));
      chk({tg[i], " early"}, vec, expRamp(ms[i] - 1, strap));
      gotoCyc(start + 4 * ms[i] + 2);
      chk({tg[i], " edge"}, vec, expRamp(ms[i], strap));
      if (i == 0) chk("R4 ldo2 strap", {6'b0, ldo2En}, {6'b0, strap});
    end
    setSrc(src, 1'b0);
    @(negedge clk);
  endtask

  task automatic ackByPin();
    ackPin = 1'b1;
    waitCyc(2);
    chk("R7 pin ack", vec, expActive(1'b0));
  endtask

  initial begin
    int st;
    bit active;
    void'($urandom(32'd4242));
    waitCyc(3);
    chk("R1 reset", vec, 7'b0);
    rstN = 1'b1;
    waitCyc(2);
    chk("R1 after reset", vec, 7'b0);

    // R2: restarted count
    btnIn = 1;
    waitCyc(4 * 20);
    btnIn = 0;
    waitCyc(2);
    btnIn = 1;
    waitCyc(4 * 20);
    btnIn = 0;
    waitCyc(2);
    chk("R2 split pulse", vec, 7'b0);
    for (int i = 0; i < 8; i++) begin
      int src = $urandom % 3;
      int len = 1 + $urandom % (DEB - 1);
      setSrc(src, 1'b1);
      waitCyc(4 * len);
      setSrc(src, 1'b0);
      waitCyc(2 + $urandom % 6);
      chk("R2 short pulse", vec, 7'b0);
    end

    // R3: event with battery low is dropped
    battLow = 1;
    usbDetIn = 1;
    waitCyc(4 * 40);
    chk("R3 battLow blocks wake", vec, 7'b0);
    usbDetIn = 0;
    battLow = 0;
    waitCyc(2);

    // R12: write in standby ignored
    writeReg(4'b0011);
    powerOn(0, 1'b0, st);
    chk("R12 standby write ignored", {6'b0, ldo2En}, 7'b0);
    ackByPin();

    // R4: ldo2 by pin and by register
    ldo2PinEn = 1;
    waitCyc(2);
    chk("R4 ldo2 pin on", {6'b0, ldo2En}, 7'd1);
    ldo2PinEn = 0;
    waitCyc(2);
    chk("R4 ldo2 pin off", {6'b0, ldo2En}, 7'd0);
    writeReg(4'b1110);
    chk("R4 ldo2 reg on", {6'b0, ldo2En}, 7'd1);
    writeReg(4'b1100);
    chk("R4 ldo2 reg off", {6'b0, ldo2En}, 7'd0);

    // R12: buck gating, buck1 untouchable
    writeReg(4'b0000);
    chk("R12 bucks gated", vec, 7'b1000101);
    writeReg(4'b1100);
    chk("R12 bucks restored", vec, expActive(1'b0));

    // R8: press while active
    btnIn = 1;
    st = cyc;
    gotoCyc(st + 4 * (DEB - 1));
    chk("R8 press early", vec, expActive(1'b0));
    gotoCyc(st + 4 * DEB + 2);
    chk("R8 press status", vec, expActive(1'b1));
    btnIn = 0;
    waitCyc(2);

    // R9: one source high keeps power
    writeReg(4'b1101);
    ackPin = 0;
    waitCyc(3);
    chk("R9 reg ack only", vec, expActive(1'b1));
    ackPin = 1;
    writeReg(4'b1100);
    chk("R9 pin ack only", vec, expActive(1'b1));

    // R10: supplies block shutdown
    usbDetIn = 1;
    ackPin = 0;
    waitCyc(3);
    chk("R10 usb holds", vec, expActive(1'b1));
    usbDetIn = 0;
    chgDetIn = 1;
    waitCyc(3);
    chk("R10 charger holds", vec, expActive(1'b1));
    chgDetIn = 0;
    waitCyc(2);
    chk("R9 R13 shutdown clears all", vec, 7'b0);

    // R4 strap path, register acknowledge
    powerOn(1, 1'b1, st);
    writeReg(4'b1101);
    chk("R7 reg ack", vec, expActive(1'b0));

    // R11 from active
    battLow = 1;
    waitCyc(2);
    chk("R11 battLow active", vec, 7'b0);
    battLow = 0;
    waitCyc(2);

    // R7 and R13: deadline with no acknowledge, register bit must be clear
    powerOn(2, 1'b0, st);
    gotoCyc(st + 4 * (T3 + ACK - 1));
    chk("R7 R13 before deadline", vec, expRamp(T3, 1'b0));
    gotoCyc(st + 4 * (T3 + ACK) + 2);
    chk("R7 R13 deadline standby", vec, 7'b0);

    // R11 during ramp
    btnIn = 1;
    waitCyc(4 * (DEB + 2));
    chk("R11 ramp powered", vec, expRamp(DEB + 1, 1'b0));
    battLow = 1;
    btnIn = 0;
    waitCyc(2);
    chk("R11 battLow ramp", vec, 7'b0);
    battLow = 0;
    waitCyc(2);

    // random acknowledge / supply / battery mixes
    active = 0;
    for (int i = 0; i < 6; i++) begin
      bit ar, ap, u, c, bl, dn;
      if (!active) begin
        powerOn($urandom % 3, 1'($urandom % 2), st);
        ackByPin();
        active = 1;
      end
      ar = 1'($urandom % 2);
      ap = 1'($urandom % 2);
      u  = 1'($urandom % 2);
      c  = 1'($urandom % 2);
      bl = (($urandom % 8) == 0);
      if (i == 1) begin ar = 0; ap = 0; u = 0; c = 0; bl = 0; end
      writeReg({3'b110, ar});
      ackPin = ap;
      usbDetIn = u;
      chgDetIn = c;
      battLow = bl;
      waitCyc(3);
      dn = expDown(ar, ap, u, c, bl);
      chk("R9 R10 R11 random mix", vec, dn ? 7'b0 : expActive(1'b0));
      ackPin = 1;
      usbDetIn = 0;
      chgDetIn = 0;
      battLow = 0;
      waitCyc(2);
      if (dn) begin
        active = 0;
        ackPin = 0;
      end
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    nTests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule